// File: doc/BRIEF.md
# Oldest-First Issue Window

This block is the central instruction window for one operational unit of an out-of-order core. A decoder pushes instructions into it one per cycle in program order. Each entry records the functional-unit class it needs, a destination tag, and two source operands. A source operand is either a value that is already known or the tag of a result that has not yet been written back. The window gives every accepted instruction a sequence number, and this number defines its age.

In every cycle the window looks at each functional-unit class on its own. Among the entries that belong to a class, have both operands available and find that class's unit free, it dispatches the oldest one. This lets a younger instruction pass an older one that is still waiting for an operand. A write-back broadcast supplies a result tag and value, and it also releases the unit of a named class. The broadcast fills in matching operands, and the value is forwarded in the same cycle, so a woken entry can issue at once. A flush carries a sequence boundary: it removes every entry younger than that boundary, and numbering restarts just after it.

Top module: `iwin_sel`

## Requirements
- R1: After reset the window is empty and `ins_ready` is 1. `ins_ready` is 0 when all N entries are occupied or `flush` is high. Each accepted instruction gets the next sequence number, starting at 0 after reset.
- R2: An entry whose operand is still pending, and that gets no matching write-back in the current cycle, is never dispatched.
- R3: A dispatch marks the unit of that class busy. No further dispatch to that class happens until a write-back whose `wb_cls` names that class has been seen in an earlier cycle.
- R4: When several entries of the same class are ready, the one with the oldest sequence number is dispatched. Age is compared modulo 2^SW.
- R5: A ready younger entry is dispatched even when older entries of the same class are still waiting.
- R6: A write-back whose `wb_tag` equals a pending operand tag makes that operand ready with the value `wb_data`. The entry may be dispatched in that same cycle, carrying `wb_data`.
- R7: When `flush` is high, no dispatch happens, every entry younger than `flush_seq` is removed, and older or equal entries stay. The next accepted instruction gets sequence number `flush_seq`+1.
- R8: Classes are selected independently, so up to NCLS instructions (class codes 0, 1 and 2) can be dispatched in one cycle. Each dispatch puts operand A, operand B, the destination tag and the sequence number on the lanes of its class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Decoder offers an instruction |
| ins_cls | input | CW | Functional-unit class code |
| ins_a_rdy | input | 1 | Operand A holds a value |
| ins_a_tag | input | TW | Operand A producer tag |
| ins_a_val | input | DW | Operand A value |
| ins_b_rdy | input | 1 | Operand B holds a value |
| ins_b_tag | input | TW | Operand B producer tag |
| ins_b_val | input | DW | Operand B value |
| ins_dst | input | TW | Destination tag |
| ins_ready | output | 1 | Window accepts the offer this cycle |
| wb_valid | input | 1 | Write-back broadcast present |
| wb_tag | input | TW | Tag of the written-back result |
| wb_data | input | DW | Written-back value |
| wb_cls | input | CW | Class whose unit is released |
| flush | input | 1 | Discard younger entries |
| flush_seq | input | SW | Flush age boundary |
| iss_valid | output | NCLS | Dispatch per class |
| iss_a | output | NCLS*DW | Operand A per class lane |
| iss_b | output | NCLS*DW | Operand B per class lane |
| iss_dst | output | NCLS*TW | Destination tag per class lane |
| iss_seq | output | NCLS*SW | Sequence number per class lane |

## Verification
Dispatch is combinational from the window state and the current write-back. For this reason the bench drives inputs on the falling edge and samples the dispatch lanes in the same low phase, with no delay at all for the same-cycle forwarding case. Occupancy, the busy state of a unit, sequence numbering and flush removal are registered, so each shows up one cycle later. The bench checks them in the cycle after the stimulus, and it observes them through `ins_ready` or through what is dispatched afterwards. Busy-unit blocking is checked both in the cycle that carries the release and in the cycle that follows it.

// File: rtl/iwin_sel.sv
module iwin_sel #(
  parameter int N    = 8,
  parameter int NCLS = 3,
  parameter int CW   = 2,
  parameter int DW   = 16,
  parameter int TW   = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ins_valid,
  input  logic [CW-1:0]        ins_cls,
  input  logic                 ins_a_rdy,
  input  logic [TW-1:0]        ins_a_tag,
  input  logic [DW-1:0]        ins_a_val,
  input  logic                 ins_b_rdy,
  input  logic [TW-1:0]        ins_b_tag,
  input  logic [DW-1:0]        ins_b_val,
  input  logic [TW-1:0]        ins_dst,
  output logic                 ins_ready,
  input  logic                 wb_valid,
  input  logic [TW-1:0]        wb_tag,
  input  logic [DW-1:0]        wb_data,
  input  logic [CW-1:0]        wb_cls,
  input  logic                 flush,
  input  logic [$clog2(N)+1:0] flush_seq,
  output logic [NCLS-1:0]      iss_valid,
  output logic [NCLS*DW-1:0]   iss_a,
  output logic [NCLS*DW-1:0]   iss_b,
  output logic [NCLS*TW-1:0]   iss_dst,
  output logic [NCLS*($clog2(N)+2)-1:0] iss_seq
);
  localparam int IW = $clog2(N);
  localparam int SW = IW + 2;

  logic [N-1:0]    vld, ar, br, a_ok, b_ok;
  logic [CW-1:0]   cls [N];
  logic [TW-1:0]   at [N], bt [N], dst [N];
  logic [DW-1:0]   av [N], bv [N], a_cur [N], b_cur [N];
  logic [SW-1:0]   seq [N];
  logic [SW-1:0]   nseq;
  logic [NCLS-1:0] busy;
  logic [N-1:0]    cand [NCLS];
  logic [N-1:0]    win [NCLS];
  logic [N-1:0]    gone;
  logic [IW-1:0]   slot;
  logic [N*SW-1:0] seq_flat;
  logic            take;

  function automatic logic younger(input logic [SW-1:0] x, input logic [SW-1:0] y);
    logic [SW-1:0] d;
    d = x - y;
    return (d != '0) && !d[SW-1];
  endfunction

  assign ins_ready = !(&vld) && !flush;
  assign take      = ins_valid && ins_ready;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      a_ok[i]  = ar[i] || (wb_valid && wb_tag == at[i]);
      b_ok[i]  = br[i] || (wb_valid && wb_tag == bt[i]);
      a_cur[i] = ar[i] ? av[i] : wb_data;
      b_cur[i] = br[i] ? bv[i] : wb_data;
      seq_flat[i*SW +: SW] = seq[i];
    end
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++)
      for (int i = 0; i < N; i++)
        cand[c][i] = vld[i] && cls[i] == CW'(c) && a_ok[i] && b_ok[i] && !busy[c] && !flush;
  end

  always_comb begin
    for (int c = 0; c < NCLS; c++)
      for (int i = 0; i < N; i++) begin
        win[c][i] = cand[c][i];
        for (int j = 0; j < N; j++)
          if (cand[c][j] && younger(seq[i], seq[j])) win[c][i] = 1'b0;
      end
  end

  always_comb begin
    iss_a = '0; iss_b = '0; iss_dst = '0; iss_seq = '0; gone = '0;
    for (int c = 0; c < NCLS; c++) begin
      iss_valid[c] = |win[c];
      gone = gone | win[c];
      for (int i = 0; i < N; i++)
        if (win[c][i]) begin
          iss_a[c*DW +: DW]   = iss_a[c*DW +: DW]   | a_cur[i];
          iss_b[c*DW +: DW]   = iss_b[c*DW +: DW]   | b_cur[i];
          iss_dst[c*TW +: TW] = iss_dst[c*TW +: TW] | dst[i];
          iss_seq[c*SW +: SW] = iss_seq[c*SW +: SW] | seq[i];
        end
    end
  end

  always_comb begin
    slot = '0;
    for (int i = N - 1; i >= 0; i--)
      if (!vld[i]) slot = IW'(i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld <= '0; ar <= '0; br <= '0; busy <= '0; nseq <= '0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush && younger(seq[i], flush_seq)) vld[i] <= 1'b0;
        else if (gone[i]) vld[i] <= 1'b0;
        else begin
          if (wb_valid && !ar[i] && wb_tag == at[i]) begin ar[i] <= 1'b1; av[i] <= wb_data; end
          if (wb_valid && !br[i] && wb_tag == bt[i]) begin br[i] <= 1'b1; bv[i] <= wb_data; end
        end
      end
      if (take) begin
        vld[slot] <= 1'b1;
        cls[slot] <= ins_cls;
        dst[slot] <= ins_dst;
        seq[slot] <= nseq;
        at[slot]  <= ins_a_tag;
        bt[slot]  <= ins_b_tag;
        ar[slot]  <= ins_a_rdy || (wb_valid && wb_tag == ins_a_tag);
        br[slot]  <= ins_b_rdy || (wb_valid && wb_tag == ins_b_tag);
        av[slot]  <= ins_a_rdy ? ins_a_val : wb_data;
        bv[slot]  <= ins_b_rdy ? ins_b_val : wb_data;
        nseq      <= nseq + 1'b1;
      end
      if (flush) nseq <= flush_seq + 1'b1;
      for (int c = 0; c < NCLS; c++)
        if (iss_valid[c]) busy[c] <= 1'b1;
        else if (wb_valid && wb_cls == CW'(c)) busy[c] <= 1'b0;
    end
  end
endmodule

module iwin_sel_chk #(
  parameter int N    = 8,
  parameter int NCLS = 3,
  parameter int SW   = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            ins_valid,
  input logic            ins_ready,
  input logic            flush,
  input logic [SW-1:0]   flush_seq,
  input logic [NCLS-1:0] iss_valid,
  input logic [N-1:0]    vld,
  input logic [N*SW-1:0] seq_flat
);
  logic [SW-1:0] fseq_q;
  logic [N-1:0]  young_live;

  always_ff @(posedge clk) fseq_q <= flush_seq;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      logic [SW-1:0] d;
      d = seq_flat[i*SW +: SW] - fseq_q;
      young_live[i] = vld[i] && d != '0 && !d[SW-1];
    end
  end

  a_r1_full_backpressure: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !ins_ready) |-> (&vld));

  a_r1_accept_count: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=>
      ($countones(vld) == $past($countones(vld)) + 1 - $past($countones(iss_valid))));

  a_r7_no_issue_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (iss_valid == '0));

  a_r7_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (young_live == '0));

  for (genvar c = 0; c < NCLS; c++) begin : g_cls
    a_r3_unit_held: assert property (@(posedge clk) disable iff (!rst_n)
      iss_valid[c] |=> !iss_valid[c]);
  end
endmodule

bind iwin_sel iwin_sel_chk #(.N(N), .NCLS(NCLS), .SW($clog2(N) + 2)) u_chk (
  .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
  .flush(flush), .flush_seq(flush_seq), .iss_valid(iss_valid),
  .vld(vld), .seq_flat(seq_flat));

// File: tb/iwin_sel_tb.sv
module iwin_sel_tb;
  localparam int N = 8, NCLS = 3, CW = 2, DW = 16, TW = 6, SW = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ins_valid, ins_a_rdy, ins_b_rdy, ins_ready, wb_valid, flush;
  logic [CW-1:0] ins_cls, wb_cls;
  logic [TW-1:0] ins_a_tag, ins_b_tag, ins_dst, wb_tag;
  logic [DW-1:0] ins_a_val, ins_b_val, wb_data;
  logic [SW-1:0] flush_seq;
  logic [NCLS-1:0] iss_valid;
  logic [NCLS*DW-1:0] iss_a, iss_b;
  logic [NCLS*TW-1:0] iss_dst;
  logic [NCLS*SW-1:0] iss_seq;
  int checks = 0, fails = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  iwin_sel #(.N(N), .NCLS(NCLS), .CW(CW), .DW(DW), .TW(TW)) u_dut (.*);

  task automatic chk(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    ins_valid = 0; ins_cls = 0; ins_a_rdy = 0; ins_a_tag = 0; ins_a_val = 0;
    ins_b_rdy = 0; ins_b_tag = 0; ins_b_val = 0; ins_dst = 0;
    wb_valid = 0; wb_tag = 0; wb_data = 0; wb_cls = 0; flush = 0; flush_seq = 0;
  endtask

  task automatic put(input int c, input logic ardy, input int atag, input int aval,
                     input int bval, input int d);
    ins_valid = 1; ins_cls = CW'(c); ins_a_rdy = ardy; ins_a_tag = TW'(atag);
    ins_a_val = DW'(aval); ins_b_rdy = 1; ins_b_tag = 6'd63; ins_b_val = DW'(bval);
    ins_dst = TW'(d);
  endtask

  task automatic wb(input int tag, input int data, input int c);
    wb_valid = 1; wb_tag = TW'(tag); wb_data = DW'(data); wb_cls = CW'(c);
  endtask

  task automatic exp_issue(input int c, input int s, input int a, input int b, input int d,
                           input string req);
    chk(iss_valid[c] === 1'b1, req, iss_valid[c], 1);
    chk(iss_seq[c*SW +: SW] === SW'(s), req, iss_seq[c*SW +: SW], s);
    chk(iss_a[c*DW +: DW] === DW'(a), req, iss_a[c*DW +: DW], a);
    chk(iss_b[c*DW +: DW] === DW'(b), req, iss_b[c*DW +: DW], b);
    chk(iss_dst[c*TW +: TW] === TW'(d), req, iss_dst[c*TW +: TW], d);
  endtask

  initial begin
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(ins_ready === 1'b1, "R1 reset ready", ins_ready, 1);
    chk(iss_valid === '0, "R1 reset no issue", iss_valid, 0);

    // fill with ALU entries, operand A pending on tag 10+k, B = 3k, dst 40+k
    for (int k = 0; k < N; k++) begin
      @(negedge clk); idle();
      put(0, 0, 10 + k, 0, 3 * k, 40 + k);
      #1;
      chk(ins_ready === 1'b1, "R1 room", ins_ready, 1);
      chk(iss_valid === '0, "R2 pending no issue", iss_valid, 0);
    end
    @(negedge clk); idle(); #1;
    chk(ins_ready === 1'b0, "R1 full", ins_ready, 0);
    chk(iss_valid === '0, "R2 all pending", iss_valid, 0);

    // R6/R5: wake seq5, same-cycle issue with forwarded value
    @(negedge clk); idle(); wb(15, 16'h55, 0); #1;
    exp_issue(0, 5, 16'h55, 15, 45, "R6 R5 forward issue");
    @(negedge clk); idle(); wb(12, 16'h12, 2); #1;
    chk(iss_valid[0] === 1'b0, "R3 busy after issue", iss_valid[0], 0);
    @(negedge clk); idle(); wb(13, 16'h13, 2); #1;
    chk(iss_valid[0] === 1'b0, "R3 busy still", iss_valid[0], 0);
    @(negedge clk); idle(); wb(63, 0, 0); #1;
    chk(iss_valid[0] === 1'b0, "R3 release cycle", iss_valid[0], 0);
    @(negedge clk); idle(); #1;
    exp_issue(0, 2, 16'h12, 6, 42, "R4 oldest of two");
    @(negedge clk); idle(); wb(63, 0, 0); #1;
    chk(iss_valid[0] === 1'b0, "R3 held", iss_valid[0], 0);
    @(negedge clk); idle(); #1;
    exp_issue(0, 3, 16'h13, 9, 43, "R4 next oldest");

    // R8: shift (seq8) and branch (seq9) wait on tag 20, woken together
    @(negedge clk); idle(); put(1, 0, 20, 0, 1, 30); #1;
    @(negedge clk); idle(); put(2, 0, 20, 0, 2, 31); #1;
    @(negedge clk); idle(); wb(20, 16'h77, 0); #1;
    chk(iss_valid === 3'b110, "R8 parallel classes", iss_valid, 6);
    exp_issue(1, 8, 16'h77, 1, 30, "R8 shift lane");
    exp_issue(2, 9, 16'h77, 2, 31, "R8 branch lane");

    // R7: flush younger than 4 (removes seq6, seq7)
    @(negedge clk); idle(); flush = 1; flush_seq = 5'd4; #1;
    chk(ins_ready === 1'b0, "R7 ready low in flush", ins_ready, 0);
    chk(iss_valid === '0, "R7 no issue in flush", iss_valid, 0);
    @(negedge clk); idle(); wb(16, 1, 2); #1;
    chk(iss_valid[0] === 1'b0, "R7 seq6 removed", iss_valid[0], 0);
    @(negedge clk); idle(); wb(17, 2, 2); #1;
    chk(iss_valid[0] === 1'b0, "R7 seq7 removed", iss_valid[0], 0);
    @(negedge clk); idle(); wb(14, 16'h14, 2); #1;
    exp_issue(0, 4, 16'h14, 12, 44, "R7 boundary kept");
    @(negedge clk); idle(); wb(63, 0, 0); put(0, 1, 0, 7, 8, 50); #1;
    chk(iss_valid[0] === 1'b0, "R3 busy in release", iss_valid[0], 0);
    @(negedge clk); idle(); #1;
    exp_issue(0, 5, 7, 8, 50, "R7 R1 renumbered after flush");
    chk(ins_ready === 1'b1, "R1 room after flush", ins_ready, 1);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule